// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a simple request port on the host side and a multiplexed-address asynchronous DRAM that keeps read data driven during CAS precharge. A request carries a 22-bit word address, a direction flag and a 4-bit write word. The controller splits the address into an 11-bit row and an 11-bit column and presents them one after the other on a shared address bus. It generates the row strobe, column strobe, write enable, output enable and the data-bus drive enable. Every interval is a whole number of clock cycles, rounded up from picosecond parameters at the configured clock period.

When back-to-back requests fall in the open row, the row strobe stays low and only the column strobe cycles, which gives the short page-mode cycle. A request to another row, an approaching limit on row-strobe low time, or a refresh request closes the page. Read data is sampled at the end of the column-strobe precharge, after the column strobe has risen, inside the extended data-out window. An external refresh agent receives a grant only once the row strobe has been high for the full precharge time, and it keeps the grant until it drops its request.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, the row strobe, column strobe, write enable and output enable are high (inactive), the data drive enable is low, and grant and read-valid are low.
- R2: The row strobe falls while the address bus carries request address bits [21:11]. The column strobe falls while it carries bits [10:0].
- R3: On the first access after a row opens, the column strobe falls exactly RCD+ASC cycles after the row strobe (4 at the defaults). Each column-strobe low pulse lasts exactly CAS cycles (2), and the column strobe then stays high for CP cycles (2) at least.
- R4: For a write, write enable is low and the data drive enable is high, with the write word on the data outputs, when the column strobe falls. Output enable stays high.
- R5: For a read, write enable is high, output enable is low and the data bus is not driven when the column strobe falls. The word on the data input at the last clock edge of column precharge is returned with a read-valid pulse exactly one cycle wide.
- R6: A request to the row already open is served with no new row-strobe falling edge.
- R7: A request to a different row raises the row strobe and keeps it high for RP cycles (7 at the defaults) before the row strobe falls again.
- R8: The row strobe never stays low for more than RAS_MAX cycles (300 in the bench setting). An idle open page is closed on its own before that limit.
- R9: The refresh grant is asserted only with the row strobe high and after at least RP cycles of precharge. An open page is closed when refresh is requested. No request is accepted while the grant is high.
- R10: Each row-strobe low period lasts at least RAS_MIN cycles (10 at the defaults).
- R11: The column strobe is never low while the row strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in [21:11], column in [10:0] |
| req_wdata | input | 4 | Write word |
| rd_valid | output | 1 | One-cycle pulse with returned read word |
| rd_data | output | 4 | Returned read word |
| ref_req | input | 1 | Refresh agent requests the memory |
| ref_gnt | output | 1 | Memory handed to refresh agent |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_a | output | 11 | Multiplexed row/column address |
| mem_dq_o | output | 4 | Write word toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 4 | Data bus as seen from the memory |

## Verification
A stuck or skipped sequencer state shows at once as a wrong count between strobe edges, because every edge is timed against the bench's own cycle counts. A corrupted open-row register appears within one request, either as an extra row-strobe fall on a page hit or as a wrong row returned by the memory model. A wrong capture point or wrong data path returns a wrong word on the next read-valid pulse. A broken limit or grant path is caught by a bench watcher on the first over-long row-strobe low time or early grant.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RSET, S_RACT, S_CSET, S_CLO, S_CHI, S_OPEN, S_PRE, S_REF
  } seq_state_t;

  function automatic int ps_to_cyc(input int ps, input int clk_ps);
    int c;
    c = (ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edo_delay_timer.sv
module edo_delay_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/edo_ras_window.sv
module edo_ras_window #(
  parameter int MIN_CYC = 10,
  parameter int MAX_CYC = 20000,
  parameter int ACC_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  output logic min_met,
  output logic expire
);
  localparam int W       = $clog2(MAX_CYC + 2);
  localparam int MIN_LIM = MIN_CYC - 1;
  localparam int EXP_LIM = MAX_CYC - ACC_CYC - 2;

  logic [W-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst || ras_n)                 lo_cnt <= '0;
    else if (lo_cnt != {W{1'b1}})     lo_cnt <= lo_cnt + 1'b1;
  end

  assign min_met = (lo_cnt >= W'(MIN_LIM));
  assign expire  = (lo_cnt >= W'(EXP_LIM));
endmodule

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
  parameter int ROW_W = 11,
  parameter int COL_W = 11
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [ROW_W-1:0]       open_row,
  output logic [ROW_W-1:0]       row,
  output logic [COL_W-1:0]       col,
  output logic                   hit
);
  assign row = addr[ROW_W+COL_W-1:COL_W];
  assign col = addr[COL_W-1:0];
  assign hit = (row == open_row);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W    = 11,
  parameter int COL_W    = 11,
  parameter int DATA_W   = 4,
  parameter int CLK_PS   = 5000,
  parameter int TASR_PS  = 0,
  parameter int TRAH_PS  = 8000,
  parameter int TRCD_PS  = 11000,
  parameter int TASC_PS  = 0,
  parameter int TCAS_PS  = 8000,
  parameter int TCP_PS   = 8000,
  parameter int TRP_PS   = 30000,
  parameter int TRAS_PS  = 50000,
  parameter int TRC_PS   = 84000,
  parameter int TRASP_PS = 100000000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  input  logic                    ref_req,
  output logic                    ref_gnt,
  output logic                    mem_ras_n,
  output logic                    mem_cas_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n,
  output logic [imax(ROW_W,COL_W)-1:0] mem_a,
  output logic [DATA_W-1:0]       mem_dq_o,
  output logic                    mem_dq_oe,
  input  logic [DATA_W-1:0]       mem_dq_i
);
  localparam int A_W     = imax(ROW_W, COL_W);
  localparam int ASR_C   = ps_to_cyc(TASR_PS, CLK_PS);
  localparam int RCD_C   = imax(ps_to_cyc(TRCD_PS, CLK_PS), ps_to_cyc(TRAH_PS, CLK_PS));
  localparam int ASC_C   = ps_to_cyc(TASC_PS, CLK_PS);
  localparam int CAS_C   = ps_to_cyc(TCAS_PS, CLK_PS);
  localparam int CP_C    = ps_to_cyc(TCP_PS, CLK_PS);
  localparam int RMIN_C  = ps_to_cyc(TRAS_PS, CLK_PS);
  localparam int RP_C    = imax(ps_to_cyc(TRP_PS, CLK_PS), ps_to_cyc(TRC_PS, CLK_PS) - RMIN_C);
  localparam int RMAX_C  = ps_to_cyc(TRASP_PS, CLK_PS);
  localparam int ACC_C   = ASC_C + CAS_C + CP_C;
  localparam int TMAX    = imax(imax(imax(ASR_C, RCD_C), imax(ASC_C, CAS_C)), imax(CP_C, RP_C));
  localparam int TMR_W   = $clog2(TMAX + 1);

  seq_state_t st, nxt;

  logic [ROW_W-1:0]  cur_row, q_row;
  logic [COL_W-1:0]  cur_col, q_col;
  logic              cur_wr, pend, q_hit;
  logic [DATA_W-1:0] cur_wd;
  logic              tload, tdone, accept;
  logic [TMR_W-1:0]  tval;
  logic              min_met, expire;

  edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr(req_addr), .open_row(cur_row), .row(q_row), .col(q_col), .hit(q_hit)
  );

  edo_delay_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tload), .load_val(tval), .done(tdone)
  );

  edo_ras_window #(.MIN_CYC(RMIN_C), .MAX_CYC(RMAX_C), .ACC_CYC(ACC_C)) u_win (
    .clk(clk), .rst(rst), .ras_n(mem_ras_n), .min_met(min_met), .expire(expire)
  );

  assign req_ready = ((st == S_IDLE) && !ref_req) ||
                     ((st == S_OPEN) && !pend && !ref_req && !expire);

  always_comb begin
    nxt    = st;
    tload  = 1'b0;
    tval   = '0;
    accept = 1'b0;
    case (st)
      S_IDLE: begin
        if (ref_req) nxt = S_REF;
        else if (req_valid) begin
          accept = 1'b1; nxt = S_RSET; tload = 1'b1; tval = TMR_W'(ASR_C - 1);
        end
      end
      S_RSET: if (tdone) begin nxt = S_RACT; tload = 1'b1; tval = TMR_W'(RCD_C - 1); end
      S_RACT: if (tdone) begin nxt = S_CSET; tload = 1'b1; tval = TMR_W'(ASC_C - 1); end
      S_CSET: if (tdone) begin nxt = S_CLO;  tload = 1'b1; tval = TMR_W'(CAS_C - 1); end
      S_CLO:  if (tdone) begin nxt = S_CHI;  tload = 1'b1; tval = TMR_W'(CP_C - 1);  end
      S_CHI:  if (tdone) nxt = S_OPEN;
      S_OPEN: begin
        if (pend || ref_req || expire) begin
          if (min_met) begin nxt = S_PRE; tload = 1'b1; tval = TMR_W'(RP_C - 1); end
        end else if (req_valid) begin
          accept = 1'b1;
          if (q_hit) begin nxt = S_CSET; tload = 1'b1; tval = TMR_W'(ASC_C - 1); end
        end
      end
      S_PRE: begin
        if (tdone) begin
          if (pend) begin nxt = S_RSET; tload = 1'b1; tval = TMR_W'(ASR_C - 1); end
          else nxt = S_IDLE;
        end
      end
      S_REF: if (!ref_req) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_wr    <= 1'b0;
      cur_wd    <= '0;
      pend      <= 1'b0;
      mem_ras_n <= 1'b1;
      mem_cas_n <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_dq_o  <= '0;
      mem_a     <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      ref_gnt   <= 1'b0;
    end else begin
      st       <= nxt;
      rd_valid <= 1'b0;
      if (accept) begin
        cur_row <= q_row;
        cur_col <= q_col;
        cur_wr  <= req_write;
        cur_wd  <= req_wdata;
        if (st == S_OPEN && !q_hit) pend <= 1'b1;
      end
      if (nxt != st) begin
        case (nxt)
          S_RSET: begin
            mem_a <= A_W'(accept ? q_row : cur_row);
            pend  <= 1'b0;
          end
          S_RACT: mem_ras_n <= 1'b0;
          S_CSET: begin
            mem_a     <= A_W'(accept ? q_col : cur_col);
            mem_we_n  <= accept ? !req_write : !cur_wr;
            mem_oe_n  <= accept ? req_write : cur_wr;
            mem_dq_oe <= accept ? req_write : cur_wr;
            mem_dq_o  <= accept ? req_wdata : cur_wd;
          end
          S_CLO:  mem_cas_n <= 1'b0;
          S_CHI:  mem_cas_n <= 1'b1;
          S_OPEN: begin
            if (!cur_wr) begin
              rd_valid <= 1'b1;
              rd_data  <= mem_dq_i;
            end
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
          end
          S_PRE:  mem_ras_n <= 1'b1;
          S_REF:  ref_gnt   <= 1'b1;
          S_IDLE: ref_gnt   <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
  parameter int CAS_C = 2
) (
  input logic clk,
  input logic rst,
  input logic mem_ras_n,
  input logic mem_cas_n,
  input logic mem_we_n,
  input logic mem_oe_n,
  input logic mem_dq_oe,
  input logic rd_valid,
  input logic ref_gnt,
  input logic req_ready
);
  logic [7:0] cas_lo;

  always_ff @(posedge clk) begin
    if (rst || mem_cas_n) cas_lo <= '0;
    else if (cas_lo != 8'hFF) cas_lo <= cas_lo + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (mem_ras_n && mem_cas_n && !mem_dq_oe && !ref_gnt && !rd_valid)); // R1
  AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (rst) !mem_cas_n |-> (cas_lo < 8'(CAS_C))); // R3
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (rst) ($fell(mem_cas_n) && !mem_we_n) |-> (mem_dq_oe && mem_oe_n)); // R4
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst) ($fell(mem_cas_n) && mem_we_n) |-> (!mem_oe_n && !mem_dq_oe)); // R5
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst) rd_valid |=> !rd_valid); // R5
  AST_GNT_PRECHARGED: assert property (@(posedge clk) disable iff (rst) ref_gnt |-> (mem_ras_n && !req_ready)); // R9
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst) !mem_cas_n |-> !mem_ras_n); // R11
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(.CAS_C(CAS_C)) u_chk (
  .clk(clk), .rst(rst), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe),
  .rd_valid(rd_valid), .ref_gnt(ref_gnt), .req_ready(req_ready)
);

// File: tb/edo_page_ctrl_test.sv
`timescale 1ns/1ps
module edo_page_ctrl_test;
  // Expected cycle counts at 5 ns: RCD=max(11,8ns)->3, ASC->1, CAS 8ns->2, CP->2,
  // RAS min 50ns->10, RP=max(6, 17-10)=7, RAS max 1.5us->300.
  localparam int E_RCD = 3, E_ASC = 1, E_CAS = 2, E_CP = 2;
  localparam int E_RMIN = 10, E_RP = 7, E_RMAX = 300;
  localparam int NV = 10;
  // {write, row[10:0], col[10:0], wdata[3:0], expected read[3:0]}
  localparam logic [30:0] VEC [NV] = '{
    {1'b1, 11'h005, 11'h003, 4'hA, 4'h0},
    {1'b1, 11'h005, 11'h7FF, 4'h5, 4'h0},
    {1'b0, 11'h005, 11'h003, 4'h0, 4'hA},
    {1'b0, 11'h005, 11'h7FF, 4'h0, 4'h5},
    {1'b1, 11'h7FF, 11'h000, 4'hC, 4'h0},
    {1'b0, 11'h7FF, 11'h000, 4'h0, 4'hC},
    {1'b0, 11'h005, 11'h003, 4'h0, 4'hA},
    {1'b1, 11'h005, 11'h003, 4'h3, 4'h0},
    {1'b0, 11'h005, 11'h003, 4'h0, 4'h3},
    {1'b0, 11'h000, 11'h001, 4'h0, 4'h0}
  };

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, ref_req = 0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic req_ready, rd_valid, ref_gnt;
  logic [3:0] rd_data, mem_dq_o, mem_dq_i;
  logic mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [10:0] mem_a;

  int checks = 0, fails = 0, cyc = 0;
  int v2 = 0, v3 = 0, v4 = 0, v5 = 0, v7 = 0, v8 = 0, v9 = 0, v10 = 0, v11 = 0;
  int ras_falls = 0;
  logic [10:0] exp_row = '0, exp_col = '0;
  logic exp_wr = 0;

  always #2.5 clk = ~clk;

  edo_page_ctrl #(.TRASP_PS(1500000)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_a(mem_a), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Memory model and protocol watcher, evaluated between clock edges.
  logic [3:0] mem [logic [21:0]];
  logic [10:0] lat_row = '0;
  logic [3:0] out_word = '0;
  logic p_ras = 1, p_cas = 1, p_rv = 0, first_cas = 0;
  int lo_run = 0, hi_run = 1000, cas_run = 0, since_ras = 0;

  assign mem_dq_i = (!mem_ras_n && !mem_oe_n && mem_we_n) ? out_word : 4'h0;

  always @(negedge clk) begin
    if (rst) begin
      p_ras = 1; p_cas = 1; p_rv = 0; hi_run = 1000; lo_run = 0;
    end else begin
      if (p_ras && !mem_ras_n) begin
        ras_falls++;
        if (mem_a != exp_row) v2++;
        if (hi_run < E_RP) v7++;
        lo_run = 0; since_ras = 0; first_cas = 1;
      end
      if (!p_ras && mem_ras_n) begin
        if (lo_run < E_RMIN) v10++;
        hi_run = 0;
      end
      if (!mem_ras_n) begin lo_run++; since_ras++; if (lo_run > E_RMAX) v8++; end
      else hi_run++;
      if (p_cas && !mem_cas_n) begin
        if (mem_a != exp_col) v2++;
        if (first_cas && since_ras != E_RCD + E_ASC + 1) v3++;
        if (!p_cas && cas_run != 0) v3++;
        first_cas = 0;
        if (exp_wr) begin
          if (mem_we_n || !mem_dq_oe || !mem_oe_n) v4++;
          mem[{lat_row, mem_a}] = mem_dq_o;
        end else begin
          if (!mem_we_n || mem_oe_n || mem_dq_oe) v5++;
          out_word = mem.exists({lat_row, mem_a}) ? mem[{lat_row, mem_a}] : 4'h0;
        end
        cas_run = 0;
      end
      if (p_ras && !mem_ras_n) lat_row = mem_a;
      if (!mem_cas_n) cas_run++;
      if (!p_cas && mem_cas_n && cas_run != E_CAS) v3++;
      if (!mem_cas_n && mem_ras_n) v11++;
      if (ref_gnt && (!mem_ras_n || hi_run < E_RP)) v9++;
      if (ref_gnt && req_ready) v9++;
      if (p_rv && rd_valid) v5++;
      p_ras = mem_ras_n; p_cas = mem_cas_n; p_rv = rd_valid;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic do_op(input logic wr, input logic [21:0] a, input logic [3:0] d,
                       output logic [3:0] rdat, output bit got);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    exp_row = a[21:11]; exp_col = a[10:0]; exp_wr = wr;
    @(negedge clk);
    req_valid = 0;
    got = 0; rdat = '0;
    if (!wr) begin
      for (int k = 0; k < 100 && !got; k++) begin
        if (rd_valid) begin got = 1; rdat = rd_data; end
        else @(negedge clk);
      end
    end else begin
      for (int k = 0; k < 100 && !mem_cas_n === 1'b0; k++) @(negedge clk);
      for (int k = 0; k < 100 && mem_cas_n !== 1'b0; k++) @(negedge clk);
    end
  endtask

  initial begin
    logic [3:0] rd;
    bit got;
    int exp_falls;
    logic [10:0] prow;
    bit open;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_ras_n && mem_cas_n && mem_we_n && mem_oe_n && !mem_dq_oe && !ref_gnt && !rd_valid,
          "R1 reset idle", {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b11110);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(mem_ras_n && mem_cas_n && !mem_dq_oe, "R1 after release", {mem_ras_n, mem_cas_n}, 2'b11);

    exp_falls = 0; open = 0; prow = '0;
    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      if (!open || v[29:19] != prow) exp_falls++;
      open = 1; prow = v[29:19];
      do_op(v[30], v[29:8], v[7:4], rd, got);
      if (!v[30]) begin
        check(got, "R5 read valid seen", got, 1);
        check(rd == v[3:0], "R5 R2 read word", rd, v[3:0]);
      end
    end
    check(ras_falls == exp_falls, "R6 R7 row opens", ras_falls, exp_falls);

    // R9: refresh closes the open page and blocks requests
    @(negedge clk); ref_req = 1;
    for (int k = 0; k < 100 && !ref_gnt; k++) @(negedge clk);
    check(ref_gnt && mem_ras_n, "R9 grant with row closed", {ref_gnt, mem_ras_n}, 2'b11);
    exp_falls = ras_falls;
    req_valid = 1; req_write = 0; req_addr = 22'h001001;
    repeat (5) begin
      @(negedge clk);
      check(!req_ready, "R9 no accept during grant", req_ready, 0);
    end
    req_valid = 0; ref_req = 0;
    @(negedge clk); @(negedge clk);
    check(!ref_gnt && ras_falls == exp_falls, "R9 grant released", {ref_gnt, 8'(ras_falls - exp_falls)}, 0);

    // R8: idle open page closes on its own
    do_op(1'b0, 22'h004802, 4'h0, rd, got);
    check(got && rd == 4'h0, "R5 unwritten read", rd, 0);
    repeat (E_RMAX + 20) @(negedge clk);
    check(mem_ras_n, "R8 idle page closed", mem_ras_n, 1);

    check(v2 == 0, "R2 address phases", v2, 0);
    check(v3 == 0, "R3 strobe spacing", v3, 0);
    check(v4 == 0, "R4 write drive", v4, 0);
    check(v5 == 0, "R5 read window", v5, 0);
    check(v7 == 0, "R7 precharge", v7, 0);
    check(v8 == 0, "R8 row low limit", v8, 0);
    check(v9 == 0, "R9 grant timing", v9, 0);
    check(v10 == 0, "R10 row low minimum", v10, 0);
    check(v11 == 0, "R11 column under row", v11, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule